// File: doc/BRIEF.md
# Edge-Latched Common-I/O Static Memory

This block is a 256-word by 4-bit static memory for a bus that runs slowly next to the chip clock and uses active-low strobes. The strobes are an enable, two selects and a write line. All of them are sampled on the system clock, and their edges are found by comparing each sample with the one taken one clock earlier. A falling enable starts a cycle and captures the address into a register. After that the address pins are ignored until the next falling enable.

Reads go through an output latch. The latch follows the addressed word while the enable is low and freezes when the enable rises, so the word stays available between cycles. A write window is open while the enable, both selects and the write line are all low. The window closes when the first of them rises, and the word on the data input at that moment is stored.

The data bus is presented as separate input, output and output-enable ports. A wrapper outside the block forms the tri-state bus. The array is built as 32 rows of 32 bits, with eight 4-bit column groups in each row.

Top module: `latched_sram`

## Requirements
- R1: The block stores 256 independent 4-bit words. A word written at any address reads back unchanged, and writing one address leaves every other address unchanged.
- R2: The address is registered from the sample in which the enable is first seen low. Address changes later in the same enable-low period have no effect on the location that is read or written.
- R3: When either select is high, `dout_oe` is low from the second clock edge after that level is sampled.
- R4: With the enable and both selects low and the write line high, `dout_oe` is high and `dout` shows the latched location. Both are valid from the second clock edge after the enable is sampled low.
- R5: While the enable is high, the output latch holds the word it had when the enable rose. If both selects are low and the write line is high, `dout_oe` stays high and `dout` does not change, even when the address changes.
- R6: A write stores the word present on `din` in the sample where the write window closes. Values driven on `din` earlier in the window, or after it has closed, are not stored.
- R7: The write window is closed by whichever of its four controls rises first: write line, enable, select 1 or select 2. Each of the four closes the window correctly.
- R8: A low write line drives `dout_oe` low from the second clock edge after it is sampled. If the write line rises while both selects and the enable are still low, the outputs re-enable and show the word just written.
- R9: With the enable held low, the latched location can be read and rewritten several times in succession. Each read shows the most recent write.
- R10: A synchronous active-high reset clears the output latch to 0 and drives `dout_oe` low. It does not change the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low enable; its falling edge captures the address |
| sel1_n | input | 1 | Active-low select, first |
| sel2_n | input | 1 | Active-low select, second |
| wr_n | input | 1 | Active-low write line |
| addr | input | 8 | Word address |
| din | input | 4 | Write data from the shared bus |
| dout | output | 4 | Read data from the output latch |
| dout_oe | output | 1 | High when the block should drive the shared bus |

## Verification
The bench moves the address pins right after the enable falls. A design that does not hold the address would read or write the wrong word. It closes the write window with each of the four controls in turn and changes `din` both before and after the closing edge. A design that stores data at the start of the window or continuously would keep the wrong value.

It holds the enable low across several reads and writes, then raises the enable and moves the address. This exposes a latch that is not bypassed with the word just written, or a latch that keeps following the array. Finally it resets between a write and its read-back, which catches a reset that clears the storage.

// File: rtl/sram_pkg.sv
package sram_pkg;

  // Sampled strobe set, all active low.
  typedef struct packed {
    logic en_n;
    logic s1_n;
    logic s2_n;
    logic wr_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{en_n: 1'b1, s1_n: 1'b1, s2_n: 1'b1, wr_n: 1'b1};

  // Device is selected only when both selects are low.
  function automatic logic is_selected(strobe_t s);
    return !s.s1_n && !s.s2_n;
  endfunction

  // Write window: all four strobes low at once.
  function automatic logic in_write_window(strobe_t s);
    return !s.en_n && is_selected(s) && !s.wr_n;
  endfunction

endpackage

// File: rtl/sram_strobe_sampler.sv
module sram_strobe_sampler
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] din_in,
  output strobe_t           cur,
  output logic              en_fall,
  output logic              en_rise,
  output logic              selected,
  output logic              win_open,
  output logic              win_close,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] din_q
);

  strobe_t prev;
  logic    win_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= STROBE_IDLE;
      prev     <= STROBE_IDLE;
      addr_q   <= '0;
      din_q    <= '0;
      win_prev <= 1'b0;
    end else begin
      cur      <= strobe_in;
      prev     <= cur;
      addr_q   <= addr_in;
      din_q    <= din_in;
      win_prev <= win_open;
    end
  end

  assign selected  = is_selected(cur);
  assign win_open  = in_write_window(cur);
  assign win_close = win_prev && !win_open;
  assign en_fall   = prev.en_n && !cur.en_n;
  assign en_rise   = !prev.en_n && cur.en_n;

  // A closing event is a single-cycle pulse.
  assert_close_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    win_close |=> !win_close);

  // A window cannot close in the same sample the enable falls.
  assert_close_not_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    en_fall |-> !win_close);

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  parameter int COL_W  = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int ROW_W    = ADDR_W - COL_W;
  localparam int N_ROWS   = 1 << ROW_W;
  localparam int N_COLS   = 1 << COL_W;
  localparam int ROW_BITS = N_COLS * DATA_W;

  logic [ROW_BITS-1:0] rows [N_ROWS];
  logic [ROW_W-1:0]    wrow, rrow;
  logic [COL_W-1:0]    wcol, rcol;
  logic [ROW_BITS-1:0] rline;
  logic [DATA_W-1:0]   col_word [N_COLS];

  // Upper bits pick the row, lower bits pick the 4-bit group.
  assign wrow = waddr[ADDR_W-1:COL_W];
  assign wcol = waddr[COL_W-1:0];
  assign rrow = raddr[ADDR_W-1:COL_W];
  assign rcol = raddr[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (we) rows[wrow][wcol*DATA_W +: DATA_W] <= wdata;
  end

  assign rline = rows[rrow];

  for (genvar g = 0; g < N_COLS; g++) begin : g_col
    assign col_word[g] = rline[g*DATA_W +: DATA_W];
  end

  assign rdata = col_word[rcol];

endmodule

// File: rtl/sram_out_latch.sv
module sram_out_latch #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_low,
  input  logic              en_rise,
  input  logic              selected,
  input  logic              wr_high,
  input  logic              win_close,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] lat,
  output logic              oe
);

  logic              upd;
  logic              valid_q;
  logic              valid_nx;
  logic [DATA_W-1:0] lat_nx;

  // Transparent while enable is low; captures once more on its rise.
  assign upd      = en_low || en_rise;
  assign valid_nx = valid_q || upd;
  assign lat_nx   = win_close ? wdata : rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat     <= '0;
      valid_q <= 1'b0;
      oe      <= 1'b0;
    end else begin
      if (upd) lat <= lat_nx;
      valid_q <= valid_nx;
      oe      <= selected && wr_high && valid_nx;
    end
  end

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!en_low && !en_rise) |=> $stable(lat));

  assert_written_word_shown_R8: assert property (@(posedge clk) disable iff (rst)
    (win_close && upd) |=> (lat == $past(wdata)));

endmodule

// File: rtl/latched_sram.sv
module latched_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  parameter int COL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              sel1_n,
  input  logic              sel2_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  strobe_t           strobe_in;
  strobe_t           cur;
  logic              en_fall, en_rise, selected, win_open, win_close;
  logic [ADDR_W-1:0] addr_q, addr_reg, rd_addr;
  logic [DATA_W-1:0] din_q, rd_data;

  assign strobe_in = '{en_n: en_n, s1_n: sel1_n, s2_n: sel2_n, wr_n: wr_n};

  sram_strobe_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sample (
    .clk(clk), .rst(rst), .strobe_in(strobe_in), .addr_in(addr), .din_in(din),
    .cur(cur), .en_fall(en_fall), .en_rise(en_rise), .selected(selected),
    .win_open(win_open), .win_close(win_close), .addr_q(addr_q), .din_q(din_q)
  );

  // Address register loads only on a falling enable.
  always_ff @(posedge clk) begin
    if (rst) addr_reg <= '0;
    else if (en_fall) addr_reg <= addr_q;
  end

  // Bypass so the first read of a cycle sees the new address.
  assign rd_addr = en_fall ? addr_q : addr_reg;

  sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_array (
    .clk(clk), .we(win_close), .waddr(addr_reg), .wdata(din_q),
    .raddr(rd_addr), .rdata(rd_data)
  );

  sram_out_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .en_low(!cur.en_n), .en_rise(en_rise),
    .selected(selected), .wr_high(cur.wr_n), .win_close(win_close),
    .wdata(din_q), .rdata(rd_data), .lat(dout), .oe(dout_oe)
  );

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (rst)
    !en_fall |=> $stable(addr_reg));

  assert_deselect_off_R3: assert property (@(posedge clk) disable iff (rst)
    (sel1_n || sel2_n) |-> ##2 !dout_oe);

  assert_write_low_off_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ##2 !dout_oe);

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!dout_oe && dout == '0));

endmodule

// File: tb/latched_sram_bench.sv
module latched_sram_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       en_n, sel1_n, sel2_n, wr_n;
  logic [7:0] addr;
  logic [3:0] din;
  logic [3:0] dout;
  logic       dout_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [3:0] model [256];
  logic [7:0] used_addr [48];

  always #4 clk = ~clk;

  latched_sram u_latched_sram (
    .clk(clk), .rst(rst), .en_n(en_n), .sel1_n(sel1_n), .sel2_n(sel2_n),
    .wr_n(wr_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  // Expected drive state from the strobe levels and latch history.
  function automatic logic exp_oe(logic e, logic s1, logic s2, logic w, logic held);
    return !s1 && !s2 && w && (!e || held);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    en_n = 1'b1; sel1_n = 1'b1; sel2_n = 1'b1; wr_n = 1'b1;
    tick(1);
  endtask

  // term: 0 write line, 1 enable, 2 select 1, 3 select 2 rises first
  task automatic do_write(logic [7:0] a, logic [3:0] d, int term);
    idle();
    addr = a; en_n = 1'b0;
    tick(1);
    addr = ~a; sel1_n = 1'b0; sel2_n = 1'b0; wr_n = 1'b0; din = ~d;
    tick(2);
    din = d;
    tick(2);
    case (term)
      0: wr_n = 1'b1;
      1: en_n = 1'b1;
      2: sel1_n = 1'b1;
      default: sel2_n = 1'b1;
    endcase
    tick(1);
    din = d ^ 4'h5;
    tick(2);
    idle();
    model[a] = d;
  endtask

  task automatic do_read(logic [7:0] a, output logic [3:0] got, output logic goe);
    idle();
    addr = a; en_n = 1'b0; sel1_n = 1'b0; sel2_n = 1'b0; wr_n = 1'b1;
    tick(1);
    addr = 8'($urandom);
    tick(3);
    got = dout; goe = dout_oe;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      finish_run();
    end
  end

  initial begin
    logic [3:0] got;
    logic       goe;
    void'($urandom(32'h1A2B3C4D));
    rst = 1'b1; en_n = 1'b1; sel1_n = 1'b1; sel2_n = 1'b1; wr_n = 1'b1;
    addr = '0; din = '0;
    tick(3);
    // R10: reset state
    chk("R10 reset oe", {3'b0, dout_oe}, 4'h0);
    chk("R10 reset dout", dout, 4'h0);
    rst = 1'b0;
    tick(2);

    // R1, R2: two neighbours in one row, address moved after the fall
    do_write(8'h10, 4'hA, 0);
    do_write(8'h11, 4'h3, 0);
    do_read(8'h10, got, goe);
    chk("R1 R2 read 0x10", got, 4'hA);
    chk("R4 oe during read", {3'b0, goe}, {3'b0, exp_oe(1'b0, 1'b0, 1'b0, 1'b1, 1'b1)});
    do_read(8'h11, got, goe);
    chk("R1 R2 read 0x11", got, 4'h3);

    // R5: hold after enable rises, address moving
    en_n = 1'b1; addr = 8'h10;
    tick(3);
    chk("R5 hold dout", dout, 4'h3);
    chk("R5 hold oe", {3'b0, dout_oe}, 4'h1);

    // R3: each select alone turns the outputs off
    sel2_n = 1'b1;
    tick(3);
    chk("R3 sel2 high", {3'b0, dout_oe}, 4'h0);
    sel2_n = 1'b0; sel1_n = 1'b1;
    tick(3);
    chk("R3 sel1 high", {3'b0, dout_oe}, 4'h0);
    sel1_n = 1'b0;
    tick(3);
    chk("R5 latch kept across deselect", dout, 4'h3);

    // R7, R6: each terminator, data changed before and after closing
    for (int t = 0; t < 4; t++) begin
      logic [7:0] a;
      logic [3:0] d;
      a = 8'h40 + 8'(t * 9);
      d = 4'(4'h6 + t);
      do_write(a, d, t);
      do_read(a, got, goe);
      chk($sformatf("R7 R6 terminator %0d", t), got, d);
    end

    // R8, R9: repeated read/modify/write with enable held low
    do_write(8'h77, 4'h1, 0);
    idle();
    addr = 8'h77; en_n = 1'b0; sel1_n = 1'b0; sel2_n = 1'b0; wr_n = 1'b1;
    tick(1);
    addr = 8'h00;
    tick(3);
    chk("R9 first read", dout, 4'h1);
    wr_n = 1'b0; din = 4'hC;
    tick(3);
    chk("R8 write low disables", {3'b0, dout_oe}, 4'h0);
    wr_n = 1'b1;
    tick(3);
    chk("R8 re-enable oe", {3'b0, dout_oe}, 4'h1);
    chk("R8 shows written word", dout, 4'hC);
    wr_n = 1'b0; din = 4'h9;
    tick(2);
    wr_n = 1'b1;
    tick(3);
    chk("R9 second rewrite", dout, 4'h9);
    en_n = 1'b1; addr = 8'h10;
    tick(3);
    chk("R5 hold after rewrite", dout, 4'h9);
    model[8'h77] = 4'h9;
    do_read(8'h77, got, goe);
    chk("R9 stored after rewrites", got, 4'h9);

    // R10: reset keeps array
    rst = 1'b1;
    tick(2);
    chk("R10 reset mid oe", {3'b0, dout_oe}, 4'h0);
    chk("R10 reset mid dout", dout, 4'h0);
    rst = 1'b0;
    tick(1);
    do_read(8'h77, got, goe);
    chk("R10 array retained", got, 4'h9);

    // R1, R7: constrained random writes and read-back
    for (int i = 0; i < 48; i++) begin
      logic [7:0] a;
      a = 8'($urandom);
      used_addr[i] = a;
      do_write(a, 4'($urandom), int'($urandom % 4));
    end
    for (int i = 0; i < 48; i++) begin
      do_read(used_addr[i], got, goe);
      chk($sformatf("R1 random read %h", used_addr[i]), got, model[used_addr[i]]);
    end

    done = 1'b1;
    finish_run();
  end

endmodule